// File: doc/BRIEF.md
# Debug Address Watchpoint Comparator

The block holds four hardware break/watch slots and compares every bus access seen on its monitor input against them. Software programs each slot through a small register interface: an address register per slot, one control word carrying per-slot enable pairs and per-slot type/length fields, and a status word with one sticky bit per slot. When an accepted access falls inside an enabled slot's window and its kind matches the slot's type, the slot's status bit is set and a single-cycle trap pulse is raised toward the trap logic.

Data windows are aligned: a slot's base is its address with the low bits cleared according to its length, and any byte of the access that lands inside the window is a hit. Execute slots instead require an instruction fetch at exactly the programmed address. A task-switch strobe drops every local enable while global enables survive.

The access monitor is a valid/ready stream. `acc_ready` is held high at all times, so the block never applies back-pressure; an access is taken on every rising edge where `acc_valid` is high, and nothing is sampled while it is low. The register port and the trap output are plain signals.

Top module: `dbg_watch_unit`

## Requirements
- R1: Register selector values 0 to 3 address the slot address registers, 4 the control word and 5 the status word (status in bits 3:0); other selectors read zero. After reset every register reads zero and `trap` is low.
- R2: Control bits 15:10 always read back zero whatever is written; bits 9:8 are stored and read back but do not change any match result.
- R3: Control bit 2i is the local enable and bit 2i+1 the global enable of slot i; either one enables the slot, and a slot with both clear never sets its status bit.
- R4: Slot i owns control bits 16+4i to 19+4i: the low two bits are its type (00 execute, 01 data write, 11 data read or write, 10 I/O) and the high two its length (00 one byte, 01 two, 11 four, 10 eight).
- R5: Access kinds on `acc_kind` are 00 fetch, 01 data read, 10 data write, 11 I/O. A write-type slot hits only on writes and a read/write-type slot on reads or writes, whenever the access bytes [addr, addr+bytes) overlap the window [base, base+len), base being the slot address with its low log2(len) bits cleared.
- R6: An execute-type slot hits only on a fetch whose address equals the slot address exactly, regardless of its length field.
- R7: An I/O-type slot never hits, an I/O-kind access never hits, and an access of zero bytes never hits.
- R8: With `WIDE_EN` set, length code 10 gives an eight-byte window; with `WIDE_EN` clear, a slot carrying length code 10 never hits.
- R9: A hit sets status bit i and it stays set until software writes the status word; a status write replaces the bits with the written value, and a hit in the same cycle still sets its bit.
- R10: `trap` is high for exactly the cycle after an accepting edge in which a status bit went from 0 to 1, and low otherwise (a repeat hit on an already set bit does not pulse it).
- R11: A `task_sw` strobe clears every local enable bit and leaves global enables and all other control bits unchanged; if a control write lands in the same cycle, the strobe is applied to the written value.
- R12: `acc_ready` is always high; an access with `acc_valid` low changes nothing; status and trap of an accepted access are visible right after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | SEL_W (3) | Register selector for read and write |
| reg_wdata | input | ADDR_W (32) | Register write data |
| reg_rdata | output | ADDR_W (32) | Combinational read data for `reg_sel` |
| acc_valid | input | 1 | Access monitor valid |
| acc_ready | output | 1 | Access monitor ready, tied high |
| acc_kind | input | 2 | Access kind code |
| acc_addr | input | ADDR_W (32) | First byte address of the access |
| acc_bytes | input | SIZE_W (4) | Number of bytes accessed |
| task_sw | input | 1 | Task-switch strobe |
| trap | output | 1 | Debug-trap pulse |

## Verification
Every result of this block lands one rising edge after its cause: a status bit and the trap pulse appear after the edge that accepts the access, a register write is readable after its edge, and the local-enable clear shows after the strobe's edge, while register reads are combinational. The bench therefore drives all inputs on a falling edge, holds them across one rising edge, and samples outputs and read data at the following falling edge; the trap's one-cycle width is checked by sampling again one falling edge later. A sweep over every type and length code, two slot alignments, all four access kinds, seventeen start addresses and six access sizes compares both a wide and a narrow instance against an arithmetic overlap model.

// File: rtl/dbgw_pkg.sv
package dbgw_pkg;

  typedef enum logic [1:0] {
    KIND_FETCH = 2'b00,
    KIND_READ  = 2'b01,
    KIND_WRITE = 2'b10,
    KIND_IO    = 2'b11
  } acc_kind_e;

  typedef enum logic [1:0] {
    BRK_EXEC  = 2'b00,
    BRK_WRITE = 2'b01,
    BRK_IO    = 2'b10,
    BRK_RDWR  = 2'b11
  } brk_type_e;

  localparam int unsigned CTRL_W     = 32;
  localparam int unsigned FIELD_BASE = 16;
  localparam int unsigned FIELD_W    = 4;
  localparam int unsigned RSVD_LO    = 10;
  localparam int unsigned RSVD_HI    = 15;
  localparam logic [1:0]  LEN_CODE_8 = 2'b10;

  // Window size in bytes for a length code (non-monotonic encoding).
  function automatic logic [3:0] len_bytes(input logic [1:0] code);
    case (code)
      2'b00:   return 4'd1;
      2'b01:   return 4'd2;
      2'b11:   return 4'd4;
      default: return 4'd8;
    endcase
  endfunction

  // Mask of the even (local) or odd (global) enable bits for n slots.
  function automatic logic [CTRL_W-1:0] enable_mask(input int n, input int odd);
    logic [CTRL_W-1:0] m;
    m = '0;
    for (int i = 0; i < n; i++) m[2*i+odd] = 1'b1;
    return m;
  endfunction

  function automatic logic [CTRL_W-1:0] reserved_mask();
    logic [CTRL_W-1:0] m;
    m = '0;
    for (int b = RSVD_LO; b <= RSVD_HI; b++) m[b] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/dbgw_ctrl_reg.sv
module dbgw_ctrl_reg
  import dbgw_pkg::*;
#(
  parameter int NUM_SLOTS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wdata,
  input  logic              task_sw,
  output logic [CTRL_W-1:0] ctrl_q
);

  localparam logic [CTRL_W-1:0] LOC_MASK  = enable_mask(NUM_SLOTS, 0);
  localparam logic [CTRL_W-1:0] GLB_MASK  = enable_mask(NUM_SLOTS, 1);
  localparam logic [CTRL_W-1:0] KEEP_MASK = ~reserved_mask();

  logic [CTRL_W-1:0] ctrl_n;

  always_comb begin
    ctrl_n = wr_en ? (wdata & KEEP_MASK) : ctrl_q;
    if (task_sw) ctrl_n = ctrl_n & ~LOC_MASK;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_n;
  end

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[RSVD_HI:RSVD_LO] == '0); // R2
  AST_TSW_LOCAL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    task_sw |=> (ctrl_q & LOC_MASK) == '0); // R11
  AST_TSW_GLOBAL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (task_sw && !wr_en) |=> (ctrl_q & GLB_MASK) == ($past(ctrl_q) & GLB_MASK)); // R11

endmodule

// File: rtl/dbgw_slot_cmp.sv
module dbgw_slot_cmp
  import dbgw_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int SIZE_W  = 4,
  parameter bit WIDE_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] slot_addr,
  input  logic [1:0]        enables,
  input  logic [FIELD_W-1:0] field,
  input  logic              acc_fire,
  input  logic [1:0]        acc_kind,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [SIZE_W-1:0] acc_bytes,
  output logic              hit
);

  localparam int XW = ADDR_W + 1;

  logic [1:0]        type_code;
  logic [1:0]        len_code;
  logic [ADDR_W-1:0] win_len;
  logic [ADDR_W-1:0] win_base;
  logic [XW-1:0]     win_end_x;
  logic [XW-1:0]     acc_end_x;
  logic              overlap;
  logic              kind_ok;
  logic              addr_ok;
  logic              len_ok;

  assign type_code = field[1:0];
  assign len_code  = field[3:2];
  assign win_len   = ADDR_W'(len_bytes(len_code));
  assign win_base  = slot_addr & ~(win_len - ADDR_W'(1));
  assign win_end_x = {1'b0, win_base} + {1'b0, win_len};
  assign acc_end_x = {1'b0, acc_addr} + XW'(acc_bytes);
  assign overlap   = ({1'b0, acc_addr} < win_end_x) && ({1'b0, win_base} < acc_end_x);
  assign len_ok    = WIDE_EN || (len_code != LEN_CODE_8);

  always_comb begin
    case (brk_type_e'(type_code))
      BRK_EXEC:  kind_ok = (acc_kind == KIND_FETCH);
      BRK_WRITE: kind_ok = (acc_kind == KIND_WRITE);
      BRK_RDWR:  kind_ok = (acc_kind == KIND_READ) || (acc_kind == KIND_WRITE);
      default:   kind_ok = 1'b0;
    endcase
  end

  assign addr_ok = (type_code == BRK_EXEC) ? (acc_addr == slot_addr) : overlap;
  assign hit = acc_fire && (|enables) && kind_ok && addr_ok && len_ok
               && (acc_bytes != '0);

  AST_VACANT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (enables == 2'b00) |-> !hit); // R3
  AST_IO_TYPE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (type_code == BRK_IO || acc_kind == KIND_IO) |-> !hit); // R7
  AST_ZERO_BYTES_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_bytes == '0) |-> !hit); // R7
  AST_EXEC_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && type_code == BRK_EXEC) |-> (acc_addr == slot_addr && acc_kind == KIND_FETCH)); // R6

endmodule

// File: rtl/dbgw_status.sv
module dbgw_status #(
  parameter int NUM_SLOTS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SLOTS-1:0] hit_vec,
  input  logic                 sw_wr,
  input  logic [NUM_SLOTS-1:0] sw_data,
  output logic [NUM_SLOTS-1:0] status_q,
  output logic                 trap_q
);

  logic [NUM_SLOTS-1:0] status_n;
  logic                 trap_n;

  always_comb begin
    status_n = (sw_wr ? sw_data : status_q) | hit_vec;
    trap_n   = |(hit_vec & ~status_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= '0;
      trap_q   <= 1'b0;
    end else begin
      status_q <= status_n;
      trap_q   <= trap_n;
    end
  end

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_wr |=> ((status_q & $past(status_q)) == $past(status_q))); // R9
  AST_TRAP_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    trap_q |-> (|(status_q & ~$past(status_q)))); // R10
  AST_HIT_SETS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit_vec) |=> ((status_q & $past(hit_vec)) == $past(hit_vec))); // R9

endmodule

// File: rtl/dbg_watch_unit.sv
module dbg_watch_unit
  import dbgw_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int NUM_SLOTS = 4,
  parameter int SIZE_W    = 4,
  parameter bit WIDE_EN   = 1'b1,
  localparam int SEL_W    = $clog2(NUM_SLOTS + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic [ADDR_W-1:0] reg_rdata,
  input  logic              acc_valid,
  output logic              acc_ready,
  input  logic [1:0]        acc_kind,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [SIZE_W-1:0] acc_bytes,
  input  logic              task_sw,
  output logic              trap
);

  localparam logic [SEL_W-1:0] SEL_CTRL = SEL_W'(NUM_SLOTS);
  localparam logic [SEL_W-1:0] SEL_STAT = SEL_W'(NUM_SLOTS + 1);

  logic [ADDR_W-1:0]    slot_addr [NUM_SLOTS];
  logic [CTRL_W-1:0]    ctrl_q;
  logic [NUM_SLOTS-1:0] hit_vec;
  logic [NUM_SLOTS-1:0] status_q;
  logic                 acc_fire;

  assign acc_ready = 1'b1;
  assign acc_fire  = acc_valid && acc_ready;

  dbgw_ctrl_reg #(.NUM_SLOTS(NUM_SLOTS)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (reg_we && reg_sel == SEL_CTRL),
    .wdata  (reg_wdata[CTRL_W-1:0]),
    .task_sw(task_sw),
    .ctrl_q (ctrl_q)
  );

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)                                 slot_addr[i] <= '0;
      else if (reg_we && reg_sel == SEL_W'(i))    slot_addr[i] <= reg_wdata;
    end

    dbgw_slot_cmp #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .WIDE_EN(WIDE_EN)) u_cmp (
      .clk      (clk),
      .rst_n    (rst_n),
      .slot_addr(slot_addr[i]),
      .enables  (ctrl_q[2*i +: 2]),
      .field    (ctrl_q[FIELD_BASE + FIELD_W*i +: FIELD_W]),
      .acc_fire (acc_fire),
      .acc_kind (acc_kind),
      .acc_addr (acc_addr),
      .acc_bytes(acc_bytes),
      .hit      (hit_vec[i])
    );
  end

  dbgw_status #(.NUM_SLOTS(NUM_SLOTS)) u_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .hit_vec (hit_vec),
    .sw_wr   (reg_we && reg_sel == SEL_STAT),
    .sw_data (reg_wdata[NUM_SLOTS-1:0]),
    .status_q(status_q),
    .trap_q  (trap)
  );

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NUM_SLOTS; i++)
      if (reg_sel == SEL_W'(i)) reg_rdata = slot_addr[i];
    if (reg_sel == SEL_CTRL) reg_rdata = ADDR_W'(ctrl_q);
    if (reg_sel == SEL_STAT) reg_rdata = ADDR_W'(status_q);
  end

  AST_IDLE_NO_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !trap); // R12
  AST_STATUS_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_sel == SEL_STAT && !acc_valid) |=> status_q == $past(reg_wdata[NUM_SLOTS-1:0])); // R9

endmodule

// File: tb/dbg_watch_unit_bench.sv
`timescale 1ns/1ps
module dbg_watch_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_sel = 3'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] rdata_w, rdata_n;
  logic        acc_valid = 1'b0;
  logic        ready_w, ready_n;
  logic [1:0]  acc_kind = 2'b00;
  logic [31:0] acc_addr = '0;
  logic [3:0]  acc_bytes = '0;
  logic        task_sw = 1'b0;
  logic        trap_w, trap_n;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  dbg_watch_unit u_dbg_watch_unit (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(rdata_w), .acc_valid(acc_valid),
    .acc_ready(ready_w), .acc_kind(acc_kind), .acc_addr(acc_addr),
    .acc_bytes(acc_bytes), .task_sw(task_sw), .trap(trap_w)
  );

  dbg_watch_unit #(.WIDE_EN(1'b0)) u_dbg_watch_unit_narrow (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(rdata_n), .acc_valid(acc_valid),
    .acc_ready(ready_n), .acc_kind(acc_kind), .acc_addr(acc_addr),
    .acc_bytes(acc_bytes), .task_sw(task_sw), .trap(trap_n)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] sel, input logic [31:0] data);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_sel(input logic [2:0] sel);
    reg_sel = sel;
    #0.5;
  endtask

  task automatic access(input logic [1:0] kind, input logic [31:0] a, input logic [3:0] n);
    @(negedge clk);
    acc_valid = 1'b1; acc_kind = kind; acc_addr = a; acc_bytes = n;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic strobe_task;
    @(negedge clk);
    task_sw = 1'b1;
    @(negedge clk);
    task_sw = 1'b0;
  endtask

  // Independent model of a single slot's hit decision.
  function automatic bit model(int t, int l, longint sa, int kind, longint a, int n, bit wide);
    longint len, base;
    bit kind_ok;
    if (n == 0 || kind == 3) return 1'b0;
    case (l)
      0: len = 1;
      1: len = 2;
      3: len = 4;
      default: begin
        if (!wide) return 1'b0;
        len = 8;
      end
    endcase
    case (t)
      0: return (kind == 0) && (a == sa);
      1: kind_ok = (kind == 2);
      3: kind_ok = (kind == 1) || (kind == 2);
      default: return 1'b0;
    endcase
    base = sa - (sa % len);
    return kind_ok && (a < base + len) && (base < a + n);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int sizes[6];
    sizes = '{0, 1, 2, 3, 4, 8};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R12: reset state
    for (int s = 0; s < 6; s++) begin
      rd_sel(3'(s));
      check("R1 reset reg", rdata_w, 32'h0);
    end
    check("R1 reset trap", {31'b0, trap_w}, 32'h0);
    check("R12 ready high", {30'b0, ready_w, ready_n}, 32'h3);

    // R2: reserved bits, flags stored
    reg_wr(3'd4, 32'hFFFF_FFFF);
    rd_sel(3'd4);
    check("R2 reserved read zero", rdata_w, 32'hFFFF_03FF);
    // R11: task switch clears locals only
    strobe_task();
    rd_sel(3'd4);
    check("R11 task switch", rdata_w, 32'hFFFF_03AA);
    // R11: strobe coincident with write acts on written value
    @(negedge clk);
    reg_we = 1'b1; reg_sel = 3'd4; reg_wdata = 32'h0000_030F; task_sw = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; task_sw = 1'b0;
    rd_sel(3'd4);
    check("R11 write plus strobe", rdata_w, 32'h0000_030A);

    // R3 / R11: global-only slot 1, write type, 4 bytes at 0x200
    reg_wr(3'd0, 32'h0);
    reg_wr(3'd1, 32'h200);
    reg_wr(3'd4, (32'hD << 20) | (32'h1 << 3));
    reg_wr(3'd5, 32'h0);
    access(2'b10, 32'h202, 4'd1);
    rd_sel(3'd5);
    check("R3 global enable hit", rdata_w, 32'h2);
    strobe_task();
    reg_wr(3'd5, 32'h0);
    access(2'b10, 32'h203, 4'd1);
    rd_sel(3'd5);
    check("R11 global survives strobe", rdata_w, 32'h2);
    // R2: exact-match flags do not change matching (execute slot 0)
    reg_wr(3'd0, 32'h300);
    reg_wr(3'd4, 32'h0000_0301);
    reg_wr(3'd5, 32'h0);
    access(2'b00, 32'h300, 4'd1);
    rd_sel(3'd5);
    check("R2 flags no effect", rdata_w, 32'h1);

    // R9 / R10: four read/write slots, four bytes each at 0x400..0x40C
    for (int s = 0; s < 4; s++) reg_wr(3'(s), 32'h400 + 32'(4 * s));
    reg_wr(3'd4, 32'hFFFF_0055);
    reg_wr(3'd5, 32'h0);
    access(2'b01, 32'h402, 4'd8);
    rd_sel(3'd5);
    check("R9 multi-slot status", rdata_w, 32'h7);
    check("R10 trap on new bits", {31'b0, trap_w}, 32'h1);
    @(negedge clk);
    check("R10 trap one cycle", {31'b0, trap_w}, 32'h0);
    access(2'b01, 32'h402, 4'd8);
    check("R10 no trap on repeat", {31'b0, trap_w}, 32'h0);
    rd_sel(3'd5);
    check("R9 sticky", rdata_w, 32'h7);
    access(2'b01, 32'h40C, 4'd1);
    rd_sel(3'd5);
    check("R9 new bit added", rdata_w, 32'hF);
    check("R10 trap slot3", {31'b0, trap_w}, 32'h1);
    reg_wr(3'd5, 32'h5);
    rd_sel(3'd5);
    check("R9 software write", rdata_w, 32'h5);
    // R9: status write and hit on slot 1 in the same cycle
    @(negedge clk);
    reg_we = 1'b1; reg_sel = 3'd5; reg_wdata = 32'h0;
    acc_valid = 1'b1; acc_kind = 2'b10; acc_addr = 32'h405; acc_bytes = 4'd1;
    @(negedge clk);
    reg_we = 1'b0; acc_valid = 1'b0;
    rd_sel(3'd5);
    check("R9 hit wins over write", rdata_w, 32'h2);
    check("R10 trap with write", {31'b0, trap_w}, 32'h1);
    // R12: valid low ignored
    reg_wr(3'd5, 32'h0);
    @(negedge clk);
    acc_kind = 2'b01; acc_addr = 32'h400; acc_bytes = 4'd4;
    @(negedge clk);
    rd_sel(3'd5);
    check("R12 invalid ignored status", rdata_w, 32'h0);
    check("R12 invalid ignored trap", {31'b0, trap_w}, 32'h0);

    // R4..R8, R3: sweep slot 0 over every type and length code
    for (int t = 0; t < 4; t++)
      for (int l = 0; l < 4; l++)
        for (int so = 0; so < 2; so++) begin
          longint sa;
          sa = (so == 0) ? 64'h100 : 64'h105;
          reg_wr(3'd0, 32'(sa));
          reg_wr(3'd4, (32'((l << 2) | t) << 16) | 32'h1);
          for (int k = 0; k < 4; k++)
            for (int d = 0; d < 17; d++)
              for (int z = 0; z < 6; z++) begin
                bit ew, en;
                longint a;
                a = 64'hF8 + d;
                ew = model(t, l, sa, k, a, sizes[z], 1'b1);
                en = model(t, l, sa, k, a, sizes[z], 1'b0);
                reg_wr(3'd5, 32'h0);
                access(2'(k), 32'(a), 4'(sizes[z]));
                rd_sel(3'd5);
                check("R5 R6 R7 R4 sweep wide", rdata_w, {31'b0, ew});
                check("R8 sweep narrow", rdata_n, {31'b0, en});
                check("R10 sweep trap", {31'b0, trap_w}, {31'b0, ew});
              end
        end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule